// File: doc/BRIEF.md
# Programmable DRAM Command Sequencer

This block turns a host-written program of memory instructions into DRAM commands, issued exactly as written. The host streams 64-bit instruction words through a ready/valid port into an instruction queue. A dispatcher then drains the queue one instruction per cycle. It drives activate, precharge, read and write commands onto a registered command/address bus, and it inserts idle cycles wherever the program contains a wait instruction. The block has no notion of DRAM timing of its own. All spacing comes from the program, so experiments can deliberately run commands closer together than any datasheet allows.

A program is a run of instructions closed by an end instruction. Dispatch starts only after a closing end instruction is held in the queue, so the whole run goes out without gaps caused by the host. After the end instruction is taken, the block raises a one-cycle done pulse and returns to idle. Read data coming back from the physical layer is forwarded to the host on its own output stream. Each returned word is labelled with the bank and column of the read it answers.

Top module: `dram_cmd_sequencer`

## Requirements
- R1: Instruction word layout: opcode in bits [63:61], bank in [60:58], row/column in [57:42], and wait count or write data in [31:0]; bits [41:32] are ignored. Opcodes are 0 end, 1 activate, 2 precharge, 3 read, 4 write, 5 wait, and 6 and 7 are reserved. Each activate, precharge, read or write instruction yields exactly one bus cycle with `cmd_code` equal to its opcode and `cmd_bank` equal to its bank. `cmd_addr` carries the row/column for activate, read and write and is 0 for precharge. `cmd_wdata` carries the data for write and is 0 otherwise.
- R2: Commands with no wait between them go out on consecutive cycles, whatever the command pair; no spacing is imposed.
- R3: A wait instruction with count N >= 1 places exactly N idle bus cycles between the command before it and the command after it. Consecutive waits add up.
- R4: A wait instruction with count 0 adds no cycle and does not occupy a queue entry.
- R5: In every cycle with no command, `cmd_code` is 0 (NOP) and `cmd_bank`, `cmd_addr` and `cmd_wdata` are 0.
- R6: No command is issued while the queue holds no end instruction, however many other instructions it holds.
- R7: `in_ready` is low whenever the queue holds `Q_DEPTH` entries (16 by default). An instruction offered while `in_ready` is low is not taken.
- R8: One cycle after `phy_rd_valid`, `host_rd_valid` is high with `host_rd_data` equal to `phy_rd_data`. Bank and column name the oldest read command that has not yet been answered, so answers keep read order.
- R9: `seq_done` is high for exactly one cycle per end instruction. With T the total count of the waits between the last command and the end instruction, it comes T+1 cycles after that last command. No command is issued in that cycle.
- R10: During and right after reset, `in_ready` is 1 and `cmd_code`, `seq_done` and `host_rd_valid` are 0.
- R11: A reserved opcode (6 or 7) issues nothing and adds exactly one idle bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host instruction valid |
| in_ready | output | 1 | Queue can take an instruction |
| in_instr | input | 64 | Instruction word |
| cmd_code | output | 3 | Command: 0 NOP, 1 activate, 2 precharge, 3 read, 4 write |
| cmd_bank | output | 3 | Command bank |
| cmd_addr | output | 16 | Row (activate) or column (read/write) |
| cmd_wdata | output | 32 | Write data |
| seq_done | output | 1 | One-cycle pulse after an end instruction |
| phy_rd_valid | input | 1 | Read data from the physical layer is valid |
| phy_rd_data | input | 32 | Read data from the physical layer |
| host_rd_valid | output | 1 | Returned read word valid |
| host_rd_data | output | 32 | Returned read word |
| host_rd_bank | output | 3 | Bank of the read being answered |
| host_rd_col | output | 16 | Column of the read being answered |

## Verification
The dispatcher is driven with four kinds of program. A plain run of commands separates correct field mapping and back-to-back issue from any added spacing. A run mixing waits of 0, 1, 3 and 5 with a reserved opcode shows exact gap counting, and it exposes an off-by-one in the counter or a zero wait that costs a cycle. A queue-filling run without an end instruction confirms that nothing goes out early and that the full queue refuses a further word. Several back-to-back reads answered by a model of the physical layer show whether returned words keep their order and carry the right bank and column.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
   localparam logic [2:0] OP_END  = 3'd0;
   localparam logic [2:0] OP_ACT  = 3'd1;
   localparam logic [2:0] OP_PRE  = 3'd2;
   localparam logic [2:0] OP_RD   = 3'd3;
   localparam logic [2:0] OP_WR   = 3'd4;
   localparam logic [2:0] OP_WAIT = 3'd5;
   localparam logic [2:0] CMD_NOP = 3'd0;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HOLD = 2'd2
   } disp_state_e;
endpackage

// File: rtl/dseq_fifo.sv
module dseq_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty,
   output logic [CW-1:0]    count
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("dseq_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + AW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/dseq_dispatch.sv
module dseq_dispatch
   import dseq_pkg::*;
#(
   parameter int BANK_W  = 3,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32,
   parameter int WAIT_W  = 32,
   parameter int INSTR_W = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      head_valid,
   input  logic [INSTR_W-1:0]        head,
   output logic                      pop,
   output logic                      end_taken,
   output logic                      rd_issue,
   output logic [BANK_W+ADDR_W-1:0]  rd_tag,
   output logic [2:0]                cmd_code,
   output logic [BANK_W-1:0]         cmd_bank,
   output logic [ADDR_W-1:0]         cmd_addr,
   output logic [DATA_W-1:0]         cmd_wdata,
   output logic                      seq_done
);
   localparam int OP_LSB   = INSTR_W - 3;
   localparam int BANK_LSB = OP_LSB - BANK_W;
   localparam int ADDR_LSB = BANK_LSB - ADDR_W;

   logic [2:0]        f_op;
   logic [BANK_W-1:0] f_bank;
   logic [ADDR_W-1:0] f_addr;
   logic [DATA_W-1:0] f_data;
   logic [WAIT_W-1:0] f_wait;
   logic              unused_head;

   assign f_op        = head[INSTR_W-1:OP_LSB];
   assign f_bank      = head[OP_LSB-1:BANK_LSB];
   assign f_addr      = head[BANK_LSB-1:ADDR_LSB];
   assign f_data      = head[DATA_W-1:0];
   assign f_wait      = head[WAIT_W-1:0];
   assign unused_head = ^head;
   assign rd_tag      = {f_bank, f_addr};

   disp_state_e       st, st_n;
   logic [WAIT_W-1:0] cnt, cnt_n;
   logic [2:0]        code_n;
   logic [BANK_W-1:0] bank_n;
   logic [ADDR_W-1:0] addr_n;
   logic [DATA_W-1:0] wdata_n;
   logic              done_n;

   always_comb begin
      st_n      = st;
      cnt_n     = cnt;
      pop       = 1'b0;
      end_taken = 1'b0;
      rd_issue  = 1'b0;
      code_n    = CMD_NOP;
      bank_n    = '0;
      addr_n    = '0;
      wdata_n   = '0;
      done_n    = 1'b0;
      unique case (st)
         ST_IDLE: if (start) st_n = ST_RUN;
         ST_RUN: begin
            if (head_valid) begin
               pop = 1'b1;
               case (f_op)
                  OP_ACT, OP_RD: begin
                     code_n   = f_op;
                     bank_n   = f_bank;
                     addr_n   = f_addr;
                     rd_issue = (f_op == OP_RD);
                  end
                  OP_WR: begin
                     code_n  = f_op;
                     bank_n  = f_bank;
                     addr_n  = f_addr;
                     wdata_n = f_data;
                  end
                  OP_PRE: begin
                     code_n = f_op;
                     bank_n = f_bank;
                  end
                  OP_WAIT: begin
                     if (f_wait > WAIT_W'(1)) begin
                        cnt_n = f_wait - WAIT_W'(1);
                        st_n  = ST_HOLD;
                     end
                  end
                  OP_END: begin
                     end_taken = 1'b1;
                     done_n    = 1'b1;
                     st_n      = ST_IDLE;
                  end
                  default: ;
               endcase
            end
         end
         ST_HOLD: begin
            cnt_n = cnt - WAIT_W'(1);
            if (cnt == WAIT_W'(1)) st_n = ST_RUN;
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         cmd_code  <= CMD_NOP;
         cmd_bank  <= '0;
         cmd_addr  <= '0;
         cmd_wdata <= '0;
         seq_done  <= 1'b0;
      end else begin
         st        <= st_n;
         cnt       <= cnt_n;
         cmd_code  <= code_n;
         cmd_bank  <= bank_n;
         cmd_addr  <= addr_n;
         cmd_wdata <= wdata_n;
         seq_done  <= done_n;
      end
   end
endmodule

// File: rtl/dram_cmd_sequencer.sv
module dram_cmd_sequencer
   import dseq_pkg::*;
#(
   parameter int BANK_W    = 3,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int WAIT_W    = 32,
   parameter int INSTR_W   = 64,
   parameter int Q_DEPTH   = 16,
   parameter int TAG_DEPTH = 8,
   parameter bit RD_TAGS   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [INSTR_W-1:0] in_instr,
   output logic [2:0]         cmd_code,
   output logic [BANK_W-1:0]  cmd_bank,
   output logic [ADDR_W-1:0]  cmd_addr,
   output logic [DATA_W-1:0]  cmd_wdata,
   output logic               seq_done,
   input  logic               phy_rd_valid,
   input  logic [DATA_W-1:0]  phy_rd_data,
   output logic               host_rd_valid,
   output logic [DATA_W-1:0]  host_rd_data,
   output logic [BANK_W-1:0]  host_rd_bank,
   output logic [ADDR_W-1:0]  host_rd_col
);
   localparam int QCW     = $clog2(Q_DEPTH + 1);
   localparam int TCW     = $clog2(TAG_DEPTH + 1);
   localparam int TAG_W   = BANK_W + ADDR_W;
   localparam int PAY_W   = (DATA_W > WAIT_W) ? DATA_W : WAIT_W;

   generate
      if (3 + BANK_W + ADDR_W + PAY_W > INSTR_W) begin : g_bad_layout
         $error("dram_cmd_sequencer: instruction fields overlap");
      end
   endgenerate

   logic [2:0]         in_op;
   logic               in_zero_wait, in_fire, q_push;
   logic               q_full, q_empty, q_pop;
   logic [QCW-1:0]     q_count;
   logic [INSTR_W-1:0] q_head;
   logic [QCW-1:0]     end_cnt;
   logic               end_in, end_taken;
   logic               rd_issue;
   logic [TAG_W-1:0]   rd_tag, tag_head;
   logic               tag_full, tag_empty;
   logic [TCW-1:0]     tag_count;

   assign in_op        = in_instr[INSTR_W-1 -: 3];
   assign in_zero_wait = (in_op == OP_WAIT) && (in_instr[WAIT_W-1:0] == '0);
   assign in_ready     = !q_full;
   assign in_fire      = in_valid && in_ready;
   assign q_push       = in_fire && !in_zero_wait;
   assign end_in       = q_push && (in_op == OP_END);

   dseq_fifo #(.WIDTH(INSTR_W), .DEPTH(Q_DEPTH)) u_iq (
      .clk(clk), .rst_n(rst_n), .push(q_push), .din(in_instr), .pop(q_pop),
      .dout(q_head), .full(q_full), .empty(q_empty), .count(q_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) end_cnt <= '0;
      else begin
         case ({end_in, end_taken})
            2'b10:   end_cnt <= end_cnt + QCW'(1);
            2'b01:   end_cnt <= end_cnt - QCW'(1);
            default: end_cnt <= end_cnt;
         endcase
      end
   end

   dseq_dispatch #(
      .BANK_W(BANK_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .WAIT_W(WAIT_W), .INSTR_W(INSTR_W)
   ) u_disp (
      .clk(clk), .rst_n(rst_n), .start(end_cnt != '0), .head_valid(!q_empty),
      .head(q_head), .pop(q_pop), .end_taken(end_taken), .rd_issue(rd_issue),
      .rd_tag(rd_tag), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .seq_done(seq_done)
   );

   generate
      if (RD_TAGS) begin : g_tags
         dseq_fifo #(.WIDTH(TAG_W), .DEPTH(TAG_DEPTH)) u_tq (
            .clk(clk), .rst_n(rst_n), .push(rd_issue), .din(rd_tag),
            .pop(phy_rd_valid), .dout(tag_head), .full(tag_full),
            .empty(tag_empty), .count(tag_count)
         );
      end else begin : g_no_tags
         logic unused_tag;
         assign unused_tag = ^{rd_tag, rd_issue};
         assign tag_head   = '0;
         assign tag_full   = 1'b0;
         assign tag_empty  = 1'b0;
         assign tag_count  = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_rd_valid <= 1'b0;
         host_rd_data  <= '0;
         host_rd_bank  <= '0;
         host_rd_col   <= '0;
      end else begin
         host_rd_valid <= phy_rd_valid;
         if (phy_rd_valid) begin
            host_rd_data <= phy_rd_data;
            host_rd_bank <= tag_head[TAG_W-1:ADDR_W];
            host_rd_col  <= tag_head[ADDR_W-1:0];
         end
      end
   end
endmodule

module dseq_checker #(
   parameter int Q_DEPTH   = 16,
   parameter int QCW       = 5,
   parameter int TAG_DEPTH = 8,
   parameter int TCW       = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic           in_ready,
   input logic [QCW-1:0] q_count,
   input logic [QCW-1:0] end_cnt,
   input logic [2:0]     cmd_code,
   input logic           seq_done,
   input logic           phy_rd_valid,
   input logic           host_rd_valid,
   input logic           tag_full,
   input logic           tag_empty,
   input logic [TCW-1:0] tag_count
);
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);
   assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> (cmd_code == 3'd0));
   assert_wait_for_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_code != 3'd0) |-> (end_cnt != '0));
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |=> (q_count <= $past(q_count)));
   assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= QCW'(Q_DEPTH));
   assert_rd_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd_valid |-> $past(phy_rd_valid));
   assert_tag_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
      phy_rd_valid |-> !tag_empty);
   assert_tag_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tag_full |-> (tag_count == TCW'(TAG_DEPTH)));
endmodule

bind dram_cmd_sequencer dseq_checker #(
   .Q_DEPTH(Q_DEPTH), .QCW(QCW), .TAG_DEPTH(TAG_DEPTH), .TCW(TCW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .q_count(q_count), .end_cnt(end_cnt), .cmd_code(cmd_code),
   .seq_done(seq_done), .phy_rd_valid(phy_rd_valid),
   .host_rd_valid(host_rd_valid), .tag_full(tag_full),
   .tag_empty(tag_empty), .tag_count(tag_count)
);

// File: tb/dram_cmd_sequencer_bench.sv
module dram_cmd_sequencer_bench;
   localparam logic [2:0] T_END = 3'd0, T_ACT = 3'd1, T_PRE = 3'd2,
                          T_RD = 3'd3, T_WR = 3'd4, T_WAIT = 3'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_instr = '0;
   logic [2:0]  cmd_code, cmd_bank;
   logic [15:0] cmd_addr;
   logic [31:0] cmd_wdata;
   logic        seq_done;
   logic        phy_rd_valid = 1'b0;
   logic [31:0] phy_rd_data = '0;
   logic        host_rd_valid;
   logic [31:0] host_rd_data;
   logic [2:0]  host_rd_bank;
   logic [15:0] host_rd_col;

   always #5 clk = ~clk;

   dram_cmd_sequencer u_dram_cmd_sequencer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_instr(in_instr), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .seq_done(seq_done),
      .phy_rd_valid(phy_rd_valid), .phy_rd_data(phy_rd_data),
      .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data),
      .host_rd_bank(host_rd_bank), .host_rd_col(host_rd_col)
   );

   typedef struct packed {
      logic [2:0]         code;
      logic [2:0]         bank;
      logic [15:0]        addr;
      logic [31:0]        wdata;
      logic signed [31:0] gap;
   } exp_t;
   typedef struct packed {
      logic [2:0]  bank;
      logic [15:0] col;
      logic [31:0] data;
   } rexp_t;

   exp_t  exp_q[$];
   string req_q[$];
   rexp_t rexp_q[$];
   int    checks = 0;
   int    errors = 0;
   int    next_gap = -1;
   bit    finished = 1'b0;

   function automatic logic [31:0] rdata(logic [2:0] b, logic [15:0] c);
      return {13'h1A5, b, c};
   endfunction

   function automatic logic [63:0] mk(logic [2:0] op, logic [2:0] b,
                                      logic [15:0] a, logic [31:0] p);
      return {op, b, a, 10'h2AA, p};
   endfunction

   task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(logic [63:0] w);
      @(negedge clk);
      in_instr = w;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic issue(logic [2:0] op, logic [2:0] b, logic [15:0] a,
                        logic [31:0] p, string req);
      exp_t e;
      case (op)
         T_ACT, T_PRE, T_RD, T_WR: begin
            e.code  = op;
            e.bank  = b;
            e.addr  = (op == T_PRE) ? 16'h0 : a;
            e.wdata = (op == T_WR) ? p : 32'h0;
            e.gap   = next_gap;
            exp_q.push_back(e);
            req_q.push_back(req);
            next_gap = 1;
            if (op == T_RD) rexp_q.push_back('{bank: b, col: a, data: rdata(b, a)});
         end
         T_WAIT: if (next_gap >= 0) next_gap += int'(p);
         T_END: begin
            e = '{code: 3'd0, bank: 3'd0, addr: 16'h0, wdata: 32'h0, gap: next_gap};
            exp_q.push_back(e);
            req_q.push_back(req);
            next_gap = -1;
         end
         default: if (next_gap >= 0) next_gap += 1;
      endcase
      push(mk(op, b, a, p));
   endtask

   // Command bus monitor and scoreboard
   int cyc = 0;
   int last_ev = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (cmd_code != 3'd0 || seq_done) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R6", "unexpected bus event code", {60'h0, seq_done, cmd_code}, 64'h0);
            end else begin
               exp_t  e;
               string r;
               e = exp_q.pop_front();
               r = req_q.pop_front();
               check(cmd_code == e.code && seq_done == (e.code == 3'd0), r, "code/done",
                     {60'h0, seq_done, cmd_code}, {60'h0, (e.code == 3'd0), e.code});
               check(cmd_bank == e.bank && cmd_addr == e.addr, r, "bank/addr",
                     {45'h0, cmd_bank, cmd_addr}, {45'h0, e.bank, e.addr});
               check(cmd_wdata == e.wdata, r, "write data", {32'h0, cmd_wdata}, {32'h0, e.wdata});
               if (e.gap >= 0)
                  check((cyc - last_ev) == e.gap, r, "cycle gap",
                        64'(cyc - last_ev), 64'(e.gap));
            end
            last_ev = cyc;
         end else begin
            check(cmd_bank == 0 && cmd_addr == 0 && cmd_wdata == 0, "R5", "idle bus fields",
                  {13'h0, cmd_bank, cmd_addr, cmd_wdata}, 64'h0);
         end
      end
   end

   // Physical-layer read model (latency 4) and host read monitor
   logic        pv[4];
   logic [2:0]  pb[4];
   logic [15:0] pc[4];
   initial for (int i = 0; i < 4; i++) begin pv[i] = 0; pb[i] = 0; pc[i] = 0; end
   always @(negedge clk) begin
      if (rst_n) begin
         check(host_rd_valid == phy_rd_valid, "R8", "return timing",
               {63'h0, host_rd_valid}, {63'h0, phy_rd_valid});
         if (host_rd_valid) begin
            if (rexp_q.size() == 0) begin
               check(1'b0, "R8", "unexpected read return", {32'h0, host_rd_data}, 64'h0);
            end else begin
               rexp_t x;
               x = rexp_q.pop_front();
               check(host_rd_data == x.data && host_rd_bank == x.bank && host_rd_col == x.col,
                     "R8", "read return", {13'h0, host_rd_bank, host_rd_col, host_rd_data},
                     {13'h0, x.bank, x.col, x.data});
            end
         end
      end
      for (int i = 3; i > 0; i--) begin pv[i] = pv[i-1]; pb[i] = pb[i-1]; pc[i] = pc[i-1]; end
      pv[0] = rst_n && (cmd_code == T_RD);
      pb[0] = cmd_bank;
      pc[0] = cmd_addr;
      phy_rd_valid = pv[3];
      phy_rd_data  = pv[3] ? rdata(pb[3], pc[3]) : 32'h0;
   end

   task automatic drain();
      while (exp_q.size() != 0 || rexp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(in_ready == 1'b1, "R10", "ready in reset", {63'h0, in_ready}, 64'h1);
      check(cmd_code == 3'd0, "R10", "cmd in reset", {61'h0, cmd_code}, 64'h0);
      check(seq_done == 1'b0, "R10", "done in reset", {63'h0, seq_done}, 64'h0);
      check(host_rd_valid == 1'b0, "R10", "rd valid in reset", {63'h0, host_rd_valid}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1 && cmd_code == 3'd0, "R10", "after reset",
            {60'h0, in_ready, cmd_code}, 64'h8);

      // Plain run: back-to-back commands; hold before end is queued (R1, R2, R6)
      issue(T_ACT, 3'd1, 16'h1234, 32'h0, "R1");
      issue(T_RD,  3'd1, 16'h0010, 32'h0, "R2");
      issue(T_WR,  3'd1, 16'h0020, 32'hDEADBEEF, "R1");
      issue(T_PRE, 3'd1, 16'h5555, 32'h0, "R1");
      repeat (20) @(negedge clk);
      check(exp_q.size() == 4, "R6", "commands held without end",
            64'(exp_q.size()), 64'd4);
      issue(T_END, 3'd0, 16'h0, 32'h0, "R9");
      drain();

      // Waits of various lengths, zero wait, reserved opcode (R3, R4, R9, R11)
      issue(T_ACT,  3'd2, 16'h0ABC, 32'h0, "R3");
      issue(T_WAIT, 3'd0, 16'h0, 32'd5, "R3");
      issue(T_RD,   3'd2, 16'h0030, 32'h0, "R3");
      issue(T_WAIT, 3'd0, 16'h0, 32'd0, "R4");
      issue(T_WAIT, 3'd0, 16'h0, 32'd1, "R4");
      issue(T_WR,   3'd2, 16'h0040, 32'h12345678, "R4");
      issue(3'd6,   3'd5, 16'hFFFF, 32'hFFFF, "R11");
      issue(T_PRE,  3'd2, 16'h0, 32'h0, "R11");
      issue(3'd7,   3'd1, 16'h1, 32'h1, "R11");
      issue(T_ACT,  3'd3, 16'h0003, 32'h0, "R11");
      issue(T_WAIT, 3'd0, 16'h0, 32'd3, "R9");
      issue(T_END,  3'd0, 16'h0, 32'h0, "R9");
      drain();

      // Several reads in a row (R8)
      issue(T_ACT, 3'd4, 16'h0100, 32'h0, "R2");
      issue(T_RD,  3'd4, 16'h0001, 32'h0, "R8");
      issue(T_RD,  3'd4, 16'h0002, 32'h0, "R8");
      issue(T_RD,  3'd6, 16'h0003, 32'h0, "R8");
      issue(T_PRE, 3'd4, 16'h0, 32'h0, "R2");
      issue(T_END, 3'd0, 16'h0, 32'h0, "R9");
      drain();

      // Fill the queue; zero wait takes no slot; full refuses (R4, R7)
      for (int i = 0; i < 15; i++)
         issue((i % 2 == 0) ? T_ACT : T_PRE, 3'(i), 16'(i * 3 + 1), 32'h0, "R7");
      issue(T_WAIT, 3'd0, 16'h0, 32'd0, "R4");
      @(negedge clk);
      check(in_ready == 1'b1, "R4", "ready after zero wait with 15 queued",
            {63'h0, in_ready}, 64'h1);
      if (in_ready) begin
         issue(T_END, 3'd0, 16'h0, 32'h0, "R9");
         check(in_ready == 1'b0, "R7", "ready when queue full", {63'h0, in_ready}, 64'h0);
         in_instr = mk(T_ACT, 3'd5, 16'hBAD0, 32'h0);
         in_valid = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
      end
      drain();

      // Final run would expose any word taken while full (R7)
      issue(T_ACT, 3'd7, 16'h0777, 32'h0, "R7");
      issue(T_END, 3'd0, 16'h0, 32'h0, "R9");
      drain();

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule